// File: doc/BRIEF.md
# Host-Side Peripheral Bus Sequencer

This block connects a simple host I/O bus to a shared parallel cable that serves many peripheral units. It claims a 32-byte window of host I/O space. On every accepted host access it captures the low address bits and, on a write, the data byte. Once the host strobe ends, it plays out a fixed-timing cable transaction: a SEND valid window, a delayed write or read strobe inside it, and, on reads, a capture pulse that stores the byte returned by the peripheral. The top location of the window is a unit-select location. A write there raises a unit-select strobe, and peripherals compare the data byte against their own identity.

A host read never waits for the cable. It returns at once whatever the read register held before the access, so a program reads the same location twice and keeps the second result. All delays and widths are counted in clock cycles. The defaults suit a 50 MHz clock. Host strobes pass through a two-flop synchronizer before edge detection.

The controller has three states. IDLE waits for an accepted access. WRITE_SEQ and READ_SEQ each run the cycle counter over the SEND window. There are four transitions:
- IDLE→WRITE_SEQ, on the trailing edge of an armed write.
- IDLE→READ_SEQ, on the trailing edge of an armed read.
- WRITE_SEQ→IDLE and READ_SEQ→IDLE, on the last SEND cycle.

An access is armed when its leading edge is seen in IDLE.

Top module: `pbus_seq`

## Requirements
- R1: An access is accepted only when host_addr[9:5] equals base_sel, host_aen_n is low and host_wr_n or host_rd_n is low. Any other access produces no cable activity.
- R2: host_addr[4:0] is captured at acceptance and drives cab_addr, with cab_addr_oe high exactly while cab_send is high. A write also captures host_wdata onto cab_data_out, and cab_data_oe is high only during a write's SEND window.
- R3: Nothing starts while the host strobe is held. cab_send rises on the second rising clock edge after the first edge that samples the released strobe.
- R4: In a write, cab_send lasts SEND_CYC (100) cycles. cab_wr is high for WR_CYC (25) cycles, starting WR_DLY (38) cycles after the first SEND cycle. cab_rd and cab_cap stay low.
- R5: In a read, cab_send lasts SEND_CYC (100) cycles. cab_rd is high for RD_CYC (50) cycles, starting RD_DLY (25) cycles into SEND. cab_cap is high for CAP_CYC (25) cycles, starting CAP_DLY (38) cycles into SEND. cab_wr stays low.
- R6: The read register loads cab_data_in on each cycle that cab_cap is high and holds its value otherwise. Its reset value is 0.
- R7: While a selected read strobe is held, host_rd_oe is high and host_rdata shows the read register as it was before this access. The byte fetched by a read appears on the next read.
- R8: cab_unit_sel is high throughout the SEND window of a write to offset 31, and never for a write to offsets 0–30 or for any read.
- R9: busy is high exactly while a cable sequence runs. An access whose leading edge arrives while busy is ignored: the running sequence keeps its timing, and the captured address and data are left unchanged.
- R10: After reset, every cable strobe, output enable, busy and host_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 5 | Window base compared with host_addr[9:5] |
| host_addr | input | 10 | Host I/O address |
| host_aen_n | input | 1 | Host address enable, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read register returned to the host |
| host_rd_oe | output | 1 | High while a selected read strobe is held |
| busy | output | 1 | Cable sequence running |
| cab_addr | output | 5 | Cable register address |
| cab_addr_oe | output | 1 | Cable address drive enable |
| cab_data_out | output | 8 | Cable write data |
| cab_data_oe | output | 1 | Cable data drive enable |
| cab_data_in | input | 8 | Byte returned by the peripheral |
| cab_send | output | 1 | Bus-valid window |
| cab_wr | output | 1 | Cable write strobe |
| cab_rd | output | 1 | Cable read strobe |
| cab_cap | output | 1 | Capture pulse for returned data |
| cab_unit_sel | output | 1 | Unit-select strobe |

## Verification
The assertions assume the host keeps its address, data and strobe stable for at least three clock cycles per access, and keeps the strobes inactive for at least three cycles between accesses. They also assume a read and a write strobe never overlap. Without these, the synchronizer could miss an edge or capture an address that is changing. The bench drives every access at the falling clock edge with a hold of several cycles. It keeps exactly one strobe active at a time. Its overlapping access starts only after a sequence has begun, so the ignore path is reached without breaking these rules.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITE_SEQ = 2'd1,
        ST_READ_SEQ  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= d_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] =  s2_q[i] && !s3_q[i];
        assign fall[i] = !s2_q[i] &&  s3_q[i];
    end
endmodule

// File: rtl/pbs_decode.sv
module pbs_decode #(
    parameter int HA_W  = 10,
    parameter int OFS_W = 5
) (
    input  logic [HA_W-1:0]       host_addr,
    input  logic [HA_W-OFS_W-1:0] base_sel,
    input  logic                  host_aen_n,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    output logic                  wsel,
    output logic                  rsel,
    output logic [OFS_W-1:0]      offset
);
    logic hit;

    always_comb begin
        hit    = (host_addr[HA_W-1:OFS_W] == base_sel) && !host_aen_n;
        wsel   = hit && !host_wr_n;
        rsel   = hit && !host_rd_n;
        offset = host_addr[OFS_W-1:0];
    end
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
    import pbs_pkg::*;
#(
    parameter int SEND_CYC = 100,
    parameter int WR_DLY   = 38,
    parameter int WR_CYC   = 25,
    parameter int RD_DLY   = 25,
    parameter int RD_CYC   = 50,
    parameter int CAP_DLY  = 38,
    parameter int CAP_CYC  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_rise,
    input  logic wr_fall,
    input  logic rd_rise,
    input  logic rd_fall,
    output logic latch_en,
    output logic in_write,
    output logic send,
    output logic wr,
    output logic rd,
    output logic cap,
    output logic busy
);
    localparam int CW = (SEND_CYC > 1) ? $clog2(SEND_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEND_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          armed_q, arm_wr_q;
    logic          start;

    function automatic logic in_win(input logic [CW-1:0] c, input int lo, input int w);
        return (int'(c) >= lo) && (int'(c) < lo + w);
    endfunction

    assign latch_en = (state_q == ST_IDLE) && !armed_q && (wr_rise || rd_rise);
    assign start    = armed_q && ((arm_wr_q && wr_fall) || (!arm_wr_q && rd_fall));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            arm_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (latch_en) begin
                armed_q  <= 1'b1;
                arm_wr_q <= wr_rise;
            end else if (start) begin
                armed_q  <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = arm_wr_q ? ST_WRITE_SEQ : ST_READ_SEQ;
            end
            ST_WRITE_SEQ, ST_READ_SEQ: begin
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        send     = 1'b0;
        wr       = 1'b0;
        rd       = 1'b0;
        cap      = 1'b0;
        in_write = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE_SEQ: begin
                send     = 1'b1;
                in_write = 1'b1;
                wr       = in_win(cnt_q, WR_DLY, WR_CYC);
            end
            ST_READ_SEQ: begin
                send = 1'b1;
                rd   = in_win(cnt_q, RD_DLY, RD_CYC);
                cap  = in_win(cnt_q, CAP_DLY, CAP_CYC);
            end
            default: ;
        endcase
        busy = send;
    end

    a_r4_wr_inside_send: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> send && in_write);
    a_r5_cap_inside_rd: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> rd && !in_write);
    a_r5_no_wr_rd_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && rd));
    a_r3_start_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send) |-> $past(wr_fall || rd_fall));
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cnt_q != LAST) |=>
            (cnt_q == $past(cnt_q) + 1'b1) && (state_q == $past(state_q)));
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq #(
    parameter int HA_W     = 10,
    parameter int OFS_W    = 5,
    parameter int DW       = 8,
    parameter int SEND_CYC = 100,
    parameter int WR_DLY   = 38,
    parameter int WR_CYC   = 25,
    parameter int RD_DLY   = 25,
    parameter int RD_CYC   = 50,
    parameter int CAP_DLY  = 38,
    parameter int CAP_CYC  = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HA_W-OFS_W-1:0] base_sel,
    input  logic [HA_W-1:0]       host_addr,
    input  logic                  host_aen_n,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    input  logic [DW-1:0]         host_wdata,
    output logic [DW-1:0]         host_rdata,
    output logic                  host_rd_oe,
    output logic                  busy,
    output logic [OFS_W-1:0]      cab_addr,
    output logic                  cab_addr_oe,
    output logic [DW-1:0]         cab_data_out,
    output logic                  cab_data_oe,
    input  logic [DW-1:0]         cab_data_in,
    output logic                  cab_send,
    output logic                  cab_wr,
    output logic                  cab_rd,
    output logic                  cab_cap,
    output logic                  cab_unit_sel
);
    localparam logic [OFS_W-1:0] UNIT_OFS = '1;

    logic             wsel, rsel;
    logic [OFS_W-1:0] offset;
    logic [1:0]       s_rise, s_fall;
    logic             latch_en, in_write;
    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    wdat_q, rreg_q;

    pbs_decode #(.HA_W(HA_W), .OFS_W(OFS_W)) u_dec (
        .host_addr (host_addr),
        .base_sel  (base_sel),
        .host_aen_n(host_aen_n),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .wsel      (wsel),
        .rsel      (rsel),
        .offset    (offset)
    );

    pbs_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({rsel, wsel}),
        .rise (s_rise),
        .fall (s_fall)
    );

    pbs_fsm #(
        .SEND_CYC(SEND_CYC), .WR_DLY(WR_DLY), .WR_CYC(WR_CYC),
        .RD_DLY(RD_DLY), .RD_CYC(RD_CYC), .CAP_DLY(CAP_DLY), .CAP_CYC(CAP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_rise (s_rise[0]),
        .wr_fall (s_fall[0]),
        .rd_rise (s_rise[1]),
        .rd_fall (s_fall[1]),
        .latch_en(latch_en),
        .in_write(in_write),
        .send    (cab_send),
        .wr      (cab_wr),
        .rd      (cab_rd),
        .cap     (cab_cap),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            wdat_q <= '0;
            rreg_q <= '0;
        end else begin
            if (latch_en) begin
                ofs_q <= offset;
                if (s_rise[0]) wdat_q <= host_wdata;
            end
            if (cab_cap) rreg_q <= cab_data_in;
        end
    end

    always_comb begin
        cab_addr     = ofs_q;
        cab_addr_oe  = cab_send;
        cab_data_out = wdat_q;
        cab_data_oe  = in_write;
        cab_unit_sel = in_write && (ofs_q == UNIT_OFS);
        host_rdata   = rreg_q;
        host_rd_oe   = rsel;
    end

    a_r6_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cab_cap |=> $stable(rreg_q));
    a_r8_unit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        cab_unit_sel |-> cab_send && !cab_rd && !cab_cap);
    a_r2_data_oe_in_send: assert property (@(posedge clk) disable iff (!rst_n)
        cab_data_oe |-> cab_addr_oe);
    a_r9_capture_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ofs_q) && $stable(wdat_q));
endmodule

// File: tb/pbus_seq_tb.sv
module pbus_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] base_sel = 5'h18;
    logic [9:0] host_addr = '0;
    logic       host_aen_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_wdata = '0, host_rdata, cab_data_out, cab_data_in;
    logic       host_rd_oe, busy, cab_addr_oe, cab_data_oe;
    logic [4:0] cab_addr;
    logic       cab_send, cab_wr, cab_rd, cab_cap, cab_unit_sel;
    logic [7:0] periph_val = 8'h00;

    int n_chk = 0, n_bad = 0;
    int s_f, s_l, w_f, w_l, r_f, r_l, c_f, c_l, u_f, u_l;
    int bad_addr, bad_data, bad_doe, bad_busy;
    logic [7:0] last_rdata;
    logic       last_oe;

    always #2 clk = ~clk;

    assign cab_data_in = cab_rd ? periph_val : 8'h00;

    pbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .host_addr(host_addr),
        .host_aen_n(host_aen_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rd_oe(host_rd_oe),
        .busy(busy), .cab_addr(cab_addr), .cab_addr_oe(cab_addr_oe),
        .cab_data_out(cab_data_out), .cab_data_oe(cab_data_oe), .cab_data_in(cab_data_in),
        .cab_send(cab_send), .cab_wr(cab_wr), .cab_rd(cab_rd), .cab_cap(cab_cap),
        .cab_unit_sel(cab_unit_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_access(input bit is_wr, input logic [9:0] a, input logic [7:0] d,
                               input int hold, input bit quiet);
        int sent = 0;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_aen_n = 1'b0;
        if (is_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            if (cab_send) sent++;
        end
        if (quiet) chk("R3 no SEND while strobe held", sent, 0);
        last_rdata = host_rdata;
        last_oe    = host_rd_oe;
        host_wr_n = 1'b1; host_rd_n = 1'b1; host_aen_n = 1'b1;
    endtask

    task automatic trace(input logic [4:0] ea, input logic [7:0] ed, input bit is_wr);
        s_f = -1; s_l = -1; w_f = -1; w_l = -1; r_f = -1; r_l = -1;
        c_f = -1; c_l = -1; u_f = -1; u_l = -1;
        bad_addr = 0; bad_data = 0; bad_doe = 0; bad_busy = 0;
        for (int k = 1; k <= 120; k++) begin
            @(negedge clk);
            if (cab_send)     begin if (s_f < 0) s_f = k; s_l = k; end
            if (cab_wr)       begin if (w_f < 0) w_f = k; w_l = k; end
            if (cab_rd)       begin if (r_f < 0) r_f = k; r_l = k; end
            if (cab_cap)      begin if (c_f < 0) c_f = k; c_l = k; end
            if (cab_unit_sel) begin if (u_f < 0) u_f = k; u_l = k; end
            if (cab_addr_oe != cab_send) bad_addr++;
            if (cab_addr_oe && cab_addr != ea) bad_addr++;
            if (cab_data_oe != (cab_send && is_wr)) bad_doe++;
            if (cab_data_oe && cab_data_out != ed) bad_data++;
            if (busy != cab_send) bad_busy++;
        end
    endtask

    task automatic t_reset;
        chk("R10 send", cab_send, 0); chk("R10 wr", cab_wr, 0);
        chk("R10 rd", cab_rd, 0); chk("R10 cap", cab_cap, 0);
        chk("R10 unit", cab_unit_sel, 0); chk("R10 busy", busy, 0);
        chk("R10 rdata", host_rdata, 0); chk("R10 oe", cab_addr_oe | cab_data_oe, 0);
    endtask

    task automatic t_write;
        host_access(1'b1, {5'h18, 5'd5}, 8'hA5, 6, 1'b1);
        trace(5'd5, 8'hA5, 1'b1);
        chk("R3 send start", s_f, 3);
        chk("R4 send last", s_l, 102);
        chk("R4 wr first", w_f, 41); chk("R4 wr last", w_l, 65);
        chk("R4 no rd", r_f, -1); chk("R4 no cap", c_f, -1);
        chk("R2 addr/oe", bad_addr, 0); chk("R2 data", bad_data, 0);
        chk("R2 data_oe", bad_doe, 0); chk("R9 busy", bad_busy, 0);
        chk("R8 no unit offs 5", u_f, -1);
    endtask

    task automatic t_unit;
        host_access(1'b1, {5'h18, 5'd31}, 8'h04, 4, 1'b1);
        trace(5'd31, 8'h04, 1'b1);
        chk("R8 unit first", u_f, 3); chk("R8 unit last", u_l, 102);
        chk("R2 data", bad_data, 0);
    endtask

    task automatic t_read;
        periph_val = 8'h3C;
        host_access(1'b0, {5'h18, 5'd3}, 8'h00, 5, 1'b1);
        chk("R7 rd_oe during read", last_oe, 1);
        chk("R7 first read old value", last_rdata, 0);
        trace(5'd3, 8'h00, 1'b0);
        chk("R5 send first", s_f, 3); chk("R5 send last", s_l, 102);
        chk("R5 rd first", r_f, 28); chk("R5 rd last", r_l, 77);
        chk("R5 cap first", c_f, 41); chk("R5 cap last", c_l, 65);
        chk("R5 no wr", w_f, -1);
        chk("R2 no data_oe in read", bad_doe, 0);
        periph_val = 8'h77;
        host_access(1'b0, {5'h18, 5'd3}, 8'h00, 5, 1'b1);
        chk("R7 second read fresh", last_rdata, 8'h3C);
        trace(5'd3, 8'h00, 1'b0);
        chk("R6 captured", host_rdata, 8'h77);
        periph_val = 8'h11;
        host_access(1'b0, {5'h18, 5'd31}, 8'h00, 4, 1'b1);
        trace(5'd31, 8'h00, 1'b0);
        chk("R8 no unit on read 31", u_f, -1);
        chk("R6 read 31 capture", host_rdata, 8'h11);
    endtask

    task automatic t_decode;
        host_access(1'b1, {5'h17, 5'd2}, 8'h55, 4, 1'b1);
        trace(5'd2, 8'h55, 1'b1);
        chk("R1 wrong base ignored", s_f, -1);
        @(negedge clk);
        host_addr = {5'h18, 5'd2}; host_aen_n = 1'b1; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        trace(5'd2, 8'h55, 1'b1);
        chk("R1 aen high ignored", s_f, -1);
        host_access(1'b0, {5'h19, 5'd2}, 8'h00, 4, 1'b1);
        chk("R1 rd_oe off wrong base", last_oe, 0);
        trace(5'd2, 8'h00, 1'b0);
        chk("R1 wrong base read ignored", s_f, -1);
    endtask

    task automatic t_busy;
        host_access(1'b1, {5'h18, 5'd9}, 8'hC3, 4, 1'b1);
        fork
            trace(5'd9, 8'hC3, 1'b1);
            begin
                repeat (20) @(negedge clk);
                host_access(1'b1, {5'h18, 5'd12}, 8'h3F, 5, 1'b0);
            end
        join
        chk("R9 send kept timing", s_l, 102);
        chk("R9 wr kept timing", w_f, 41);
        chk("R9 addr unchanged", bad_addr, 0);
        chk("R9 data unchanged", bad_data, 0);
        chk("R9 busy level", bad_busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_unit();
        t_read();
        t_decode();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule